// File: doc/BRIEF.md
# Ripple-Matrix Threshold Weight Comparator

This block decides, with no clock and no adder, whether an input vector holds at least a fixed number of set bits. The count is never formed as a binary number. A rectangular mesh of identical cells does the work. Each cell column belongs to one input bit, and each cell row stands for one more set bit found. A set bit pulls down the first row that has not yet fallen, at its own column. A fallen row stays low up to the right-hand edge. Once the row for the last counted bit has fallen, the threshold is met.

The width and the threshold are elaboration-time parameters. Two options change the structure but never the decision. The first option picks the counting polarity. The mesh can count ones on THRESH rows, or count zeros on N_BITS−THRESH+1 rows and invert the result. An automatic setting picks whichever polarity needs fewer rows. The second option picks the mesh shape. The full rectangle reduces every row end. The trimmed band keeps only the cells that can still affect the last row, and watches that row alone. A threshold of zero, or a threshold above the width, ties the flag to a constant.

Top module: `hcmp_fixed_thresh`

## Requirements
- R1: For 1 ≤ THRESH ≤ N_BITS, `ge_o` is 1 exactly when the number of ones in `vec_i` is at least THRESH, whatever bit positions the ones occupy.
- R2: With THRESH ≥ 1, an all-zero `vec_i` gives `ge_o` = 0. An all-ones `vec_i` gives `ge_o` = 1.
- R3: With THRESH = 0, `ge_o` is 1 for every input.
- R4: With THRESH > N_BITS, `ge_o` is 0 for every input.
- R5: With SCAN_PICK = SCAN_ZEROS, the mesh counts zero bits on N_BITS−THRESH+1 rows and inverts its result. The flag equals the one R1 defines.
- R6: With TRIM = 1, the trimmed band mesh monitors only the last row. The flag equals the one the full rectangle gives.
- R7: With SCAN_PICK = SCAN_AUTO, the polarity with fewer rows is chosen: ones on THRESH rows, or zeros on N_BITS−THRESH+1 rows. A tie counts ones. The flag equals the one R1 defines.
- R8: At the boundary, an input weight of exactly THRESH gives 1 and a weight of THRESH−1 gives 0. This includes THRESH = N_BITS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_i | input | N_BITS | Vector whose set bits are counted |
| ge_o | output | 1 | 1 when the weight of `vec_i` is at least THRESH |

## Verification
The threshold decision and the ripple tail can fall on the same input. This happens when the THRESH-th one sits in the rightmost column. The last row then falls in the very column that feeds the flag. A weight of THRESH−1 with the missing one at the far right must leave the flag low.

Every code of a 12-bit vector is applied, and its low 8 bits go to the 8-bit instances. Each such boundary vector therefore reaches ones-counting, zeros-counting, full and trimmed meshes in the same cycle. Each instance is judged each cycle against a behavioural popcount. The result is tagged with the boundary requirement whenever the weight is THRESH or THRESH−1.

// File: rtl/hcmp_pkg.sv
package hcmp_pkg;

   typedef enum logic [1:0] {
      SCAN_AUTO  = 2'd0,
      SCAN_ONES  = 2'd1,
      SCAN_ZEROS = 2'd2
   } scan_pick_e;

   // rows needed when set bits are counted
   function automatic int ones_rows(input int n, input int t);
      return t;
   endfunction

   // rows needed when clear bits are counted: zeros >= n-t+1 means weight < t
   function automatic int zero_rows(input int n, input int t);
      return n - t + 1;
   endfunction

   function automatic bit pick_zeros(input scan_pick_e pick, input int n, input int t);
      if (pick == SCAN_ZEROS) return 1'b1;
      if (pick == SCAN_ONES)  return 1'b0;
      return (zero_rows(n, t) < ones_rows(n, t));
   endfunction

endpackage

// File: rtl/hcmp_node.sv
// One mesh cell: a row level passes east unless this column's bit is set
// while the row above had already fallen before this column.
module hcmp_node (
   input  logic bit_i,
   input  logic west_i,
   input  logic up_i,
   output logic east_o
);
   logic bit_n;
   logic take;
   logic west_n;

   assign bit_n  = ~bit_i;
   assign take   = ~(bit_n | up_i);     // NOR: bit set and upper row low
   assign west_n = ~west_i;
   assign east_o = ~(west_n | take);    // NOR: stay high unless taken
endmodule

// File: rtl/hcmp_grid.sv
// ROWS x COLS ripple mesh. TRIM=0 builds the full rectangle and reduces all
// row ends; TRIM=1 builds only the band k <= j <= COLS-ROWS+k.
module hcmp_grid #(
   parameter int COLS = 8,
   parameter int ROWS = 3,
   parameter bit TRIM = 1'b0
) (
   input  logic [COLS-1:0] bits_i,
   output logic            hit_o
);
   localparam int SPAN = COLS - ROWS;

   for (genvar k = 1; k <= ROWS; k++) begin : g_row
      localparam int LO = TRIM ? k : 1;
      localparam int HI = TRIM ? (SPAN + k) : COLS;
      logic [HI:LO] east_v;

      for (genvar j = LO; j <= HI; j++) begin : g_col
         logic west_w;
         logic up_w;

         if (j == LO) begin : g_w_edge
            assign west_w = 1'b1;
         end else begin : g_w_link
            assign west_w = east_v[j-1];
         end

         if (k == 1) begin : g_u_top
            assign up_w = 1'b0;
         end else if (j == 1) begin : g_u_edge
            assign up_w = 1'b1;
         end else begin : g_u_link
            assign up_w = g_row[k-1].east_v[j-1];
         end

         hcmp_node u_node (
            .bit_i  (bits_i[j-1]),
            .west_i (west_w),
            .up_i   (up_w),
            .east_o (east_v[j])
         );
      end
   end

   if (TRIM) begin : g_last_only
      assign hit_o = ~g_row[ROWS].east_v[COLS];
   end else begin : g_all_ends
      logic [ROWS:1] ends_w;
      for (genvar k = 1; k <= ROWS; k++) begin : g_end
         assign ends_w[k] = g_row[k].east_v[COLS];
      end
      assign hit_o = ~|ends_w;
   end
endmodule

// File: rtl/hcmp_orient.sv
// Polarity adapter: counting zeros inverts the scanned bits and the verdict.
module hcmp_orient #(
   parameter int N_BITS = 8,
   parameter bit INVERT = 1'b0
) (
   input  logic [N_BITS-1:0] vec_i,
   input  logic              hit_i,
   output logic [N_BITS-1:0] scan_o,
   output logic              ge_o
);
   assign scan_o = vec_i ^ {N_BITS{INVERT}};
   assign ge_o   = hit_i ^ INVERT;
endmodule

// File: rtl/hcmp_fixed_thresh.sv
module hcmp_fixed_thresh #(
   parameter int                     N_BITS    = 8,
   parameter int                     THRESH    = 3,
   parameter hcmp_pkg::scan_pick_e   SCAN_PICK = hcmp_pkg::SCAN_AUTO,
   parameter bit                     TRIM      = 1'b0
) (
   input  logic [N_BITS-1:0] vec_i,
   output logic              ge_o
);
   localparam bit USE_ZEROS = hcmp_pkg::pick_zeros(SCAN_PICK, N_BITS, THRESH);
   localparam int MESH_ROWS = USE_ZEROS ? hcmp_pkg::zero_rows(N_BITS, THRESH)
                                        : hcmp_pkg::ones_rows(N_BITS, THRESH);
   localparam int MAX_CELLS = 4096;

   if (N_BITS < 1) begin : g_bad_width
      $error("hcmp_fixed_thresh: N_BITS must be at least 1");
   end
   if (THRESH < 0) begin : g_bad_thresh
      $error("hcmp_fixed_thresh: THRESH must not be negative");
   end
   if (THRESH >= 1 && THRESH <= N_BITS && MESH_ROWS * N_BITS > MAX_CELLS) begin : g_too_big
      $error("hcmp_fixed_thresh: mesh exceeds cell budget");
   end

   if (THRESH == 0) begin : g_tie_high
      logic unused_vec;
      assign unused_vec = ^vec_i;
      assign ge_o       = 1'b1;
   end else if (THRESH > N_BITS) begin : g_tie_low
      logic unused_vec;
      assign unused_vec = ^vec_i;
      assign ge_o       = 1'b0;
   end else begin : g_mesh
      logic [N_BITS-1:0] scan_w;
      logic              hit_w;

      hcmp_orient #(
         .N_BITS (N_BITS),
         .INVERT (USE_ZEROS)
      ) u_orient (
         .vec_i  (vec_i),
         .hit_i  (hit_w),
         .scan_o (scan_w),
         .ge_o   (ge_o)
      );

      hcmp_grid #(
         .COLS (N_BITS),
         .ROWS (MESH_ROWS),
         .TRIM (TRIM)
      ) u_grid (
         .bits_i (scan_w),
         .hit_o  (hit_w)
      );
   end
endmodule

// File: rtl/hcmp_fixed_thresh_chk.sv
module hcmp_fixed_thresh_chk #(
   parameter int N_BITS = 8,
   parameter int THRESH = 3
) (
   input logic [N_BITS-1:0] vec_i,
   input logic              ge_o
);
   int weight;

   always_comb begin
      weight = 0;
      for (int i = 0; i < N_BITS; i++) weight += int'(vec_i[i]);
   end

   always_comb begin
      if (THRESH >= 1 && THRESH <= N_BITS) begin
         p_ge_match_r1 : assert (ge_o == (weight >= THRESH))
            else $error("R1 flag %0b weight %0d", ge_o, weight);
         if (vec_i == '0) begin
            p_zero_in_r2 : assert (ge_o == 1'b0)
               else $error("R2 zero input raised flag");
         end
         if (weight == THRESH) begin
            p_edge_hit_r8 : assert (ge_o == 1'b1)
               else $error("R8 weight at threshold not flagged");
         end
      end
      if (THRESH == 0) begin
         p_tie_high_r3 : assert (ge_o == 1'b1) else $error("R3 flag low");
      end
      if (THRESH > N_BITS) begin
         p_tie_low_r4 : assert (ge_o == 1'b0) else $error("R4 flag high");
      end
   end
endmodule

bind hcmp_fixed_thresh hcmp_fixed_thresh_chk #(
   .N_BITS (N_BITS),
   .THRESH (THRESH)
) u_chk (
   .vec_i (vec_i),
   .ge_o  (ge_o)
);

// File: tb/test_hcmp_fixed_thresh.sv
module test_hcmp_fixed_thresh;
   import hcmp_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] vec = '0;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   logic ge_a, ge_b, ge_c, ge_d, ge_e, ge_f, ge_g;

   always #5 clk = ~clk;

   // R1/R2/R8: 8 bits, threshold 3, auto picks ones, full mesh
   hcmp_fixed_thresh #(.N_BITS(8), .THRESH(3)) i_hcmp_fixed_thresh (
      .vec_i(vec[7:0]), .ge_o(ge_a));
   // R5: forced zero counting, trimmed
   hcmp_fixed_thresh #(.N_BITS(8), .THRESH(3), .SCAN_PICK(SCAN_ZEROS), .TRIM(1'b1))
      i_hcmp_zeros (.vec_i(vec[7:0]), .ge_o(ge_b));
   // R3
   hcmp_fixed_thresh #(.N_BITS(8), .THRESH(0)) i_hcmp_t0 (.vec_i(vec[7:0]), .ge_o(ge_c));
   // R4
   hcmp_fixed_thresh #(.N_BITS(8), .THRESH(9)) i_hcmp_over (.vec_i(vec[7:0]), .ge_o(ge_d));
   // R8 with THRESH = N_BITS, ones forced, trimmed
   hcmp_fixed_thresh #(.N_BITS(8), .THRESH(8), .SCAN_PICK(SCAN_ONES), .TRIM(1'b1))
      i_hcmp_full (.vec_i(vec[7:0]), .ge_o(ge_e));
   // R6: trimmed band, 12 bits
   hcmp_fixed_thresh #(.N_BITS(12), .THRESH(5), .TRIM(1'b1)) i_hcmp_band (
      .vec_i(vec), .ge_o(ge_f));
   // R7: auto picks zeros (3 rows instead of 10)
   hcmp_fixed_thresh #(.N_BITS(12), .THRESH(10)) i_hcmp_auto (.vec_i(vec), .ge_o(ge_g));

   function automatic int ones_in(input logic [11:0] v, input int w);
      int c = 0;
      for (int i = 0; i < w; i++) c += int'(v[i]);
      return c;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s vec=%03h actual=%0b expected=%0b", req, vec, act, exp);
      end
   endtask

   task automatic check_all();
      int w8  = ones_in(vec, 8);
      int w12 = ones_in(vec, 12);
      if (vec[7:0] == 8'h00 || vec[7:0] == 8'hFF)
         check("R2", ge_a, w8 >= 3);
      else if (w8 == 3 || w8 == 2)
         check("R8", ge_a, w8 >= 3);
      else
         check("R1", ge_a, w8 >= 3);
      check("R5", ge_b, w8 >= 3);
      check("R3", ge_c, 1'b1);
      check("R4", ge_d, 1'b0);
      if (w8 >= 7) check("R8", ge_e, w8 >= 8);
      else         check("R1", ge_e, 1'b0);
      check("R6", ge_f, w12 >= 5);
      check("R7", ge_g, w12 >= 10);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R2", ge_a, 1'b0);   // reset state: all-zero vector
      check("R3", ge_c, 1'b1);
      rst = 1'b0;
      for (int v = 0; v < 4096; v++) begin
         @(posedge clk);
         vec <= 12'(v);
         @(negedge clk);
         check_all();
      end
      // threshold-th one in the rightmost column of the 8-bit mesh
      @(posedge clk); vec <= 12'h083;
      @(negedge clk); check("R8", ge_a, 1'b1);
      @(posedge clk); vec <= 12'h081;
      @(negedge clk); check("R8", ge_a, 1'b0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule